// File: doc/BRIEF.md
# I2C Status Flag Register

This block holds two sticky status flags for an I2C controller. The first is transmit-buffer-empty. It tells software that the transmit data buffer can take the next byte. The second is arbitration-lost. It tells software that another master took the bus.

The block watches several sources of events:
- strobes from the controller datapath;
- the mode bits;
- the value the controller drives onto SDA;
- the raw SCL and SDA pins, which it synchronizes internally.

Software reads the flags through a simple register strobe. It clears a flag by writing 0 to it, but only after it has read that flag as 1. An interrupt request is raised from the flags through per-flag enables.

The byte shifter, the SCL generator and the receive path are separate blocks. This block sees them only through its strobes and mode inputs.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset both flags read 0 and the interrupt request is 0.
- R2: A pulse on `xfer_load_i` sets the transmit-empty flag on the next clock edge.
- R3: A rising edge on `tx_sel_i` sets the transmit-empty flag. This covers a slave that turns from receiving to transmitting.
- R4: A pulse on `txbuf_wr_i` clears the transmit-empty flag, unless a set event occurs in the same cycle.
- R5: With `mst_i` and `tx_sel_i` both 1, a synchronized SCL rising edge where the synchronized SDA pin differs from `sda_drive_i` sets the arbitration-lost flag. If either mode bit is 0, or the two SDA values agree, that edge does not set the flag.
- R6: With `mst_i` at 1, a start condition sets the arbitration-lost flag while `sda_drive_i` is 1. A start condition is synchronized SDA falling while synchronized SCL stays high. The flag is not set when `sda_drive_i` is 0 or `mst_i` is 0.
- R7: Field positions: `reg_wdata_i[1]` is the transmit-empty flag and `reg_wdata_i[0]` is arbitration-lost.
  - A `reg_rd_i` pulse while a flag is 1 arms that flag.
  - A write with that flag's bit at 0 clears an armed flag.
  - A write of 0 to a flag that is not armed has no effect. This includes a flag that was read while it was still 0.
  - Writing 1 to a flag has no effect.
  - `txbuf_wr_i` never clears arbitration-lost.
- R8: Any register write disarms both flags. A read, then a write of 1, then a write of 0 leaves the flag set.
- R9: When a set event and a clear of the same flag fall in the same cycle, the flag ends at 1.
- R10: `irq_o` is 1 when either of these holds: transmit-empty is 1 with `irq_en_i[1]` at 1, or arbitration-lost is 1 with `irq_en_i[0]` at 1.
- R11: With the default two-stage synchronizer, a pin change made between clock edges shows in the flag after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_load_i | input | 1 | Transmit buffer moved into the shift register |
| txbuf_wr_i | input | 1 | CPU write to the transmit data buffer |
| mst_i | input | 1 | Master mode |
| tx_sel_i | input | 1 | Transmit mode select |
| sda_drive_i | input | 1 | SDA value the controller drives |
| scl_pin_i | input | 1 | Raw SCL pin |
| sda_pin_i | input | 1 | Raw SDA pin |
| reg_rd_i | input | 1 | Status register read strobe |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 2 | Write data, bit 1 transmit-empty, bit 0 arbitration-lost |
| irq_en_i | input | 2 | Interrupt enables, bit 1 transmit-empty, bit 0 arbitration-lost |
| flag_tx_o | output | 1 | Transmit-empty flag |
| flag_al_o | output | 1 | Arbitration-lost flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the transfer strobe and a rising transmit select always leave transmit-empty set;
- a buffer write with no competing set leaves it clear;
- arbitration-lost only falls right after a write of 0 to its bit;
- a flag cannot fall under a write of 1;
- the interrupt never rises without a flag.

Some behaviours need a prepared history, so only the bench scenarios can show them. These are the armed state (read-before-clear, disarming after a write, a read of 0 that does not arm), the mode and data sweeps for both arbitration-loss causes, set-versus-clear collisions and the synchronizer latency.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int FLAG_W = 2;
  localparam int IDX_AL = 0;
  localparam int IDX_TX = 1;

  typedef struct packed {
    logic scl_rise;
    logic start;
  } bus_evt_t;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cst_bus_evt.sv
module i2cst_bus_evt
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_pin_i,
  input  logic     sda_pin_i,
  output bus_evt_t evt_o,
  output logic     sda_s_o
);
  logic scl_s, sda_s;
  logic scl_q, sda_q;

  i2cst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_pin_i), .q_o(scl_s)
  );
  i2cst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_pin_i), .q_o(sda_s)
  );

  // previous-sample registers for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt_o.scl_rise = scl_s & ~scl_q;
    evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
  end

  assign sda_s_o = sda_s;
endmodule

// File: rtl/i2cst_flag_cell.sv
module i2cst_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic sw_clr;
  logic upd_en;

  always_comb begin
    sw_clr  = wr_i & ~wbit_i & armed_q;
    // a set event overrides any clear in the same cycle
    flag_d  = set_i | (flag_q & ~(sw_clr | hw_clr_i));
    armed_d = wr_i ? 1'b0 : (armed_q | (rd_i & flag_q));
    upd_en  = set_i | hw_clr_i | rd_i | wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_load_i,
  input  logic              txbuf_wr_i,
  input  logic              mst_i,
  input  logic              tx_sel_i,
  input  logic              sda_drive_i,
  input  logic              scl_pin_i,
  input  logic              sda_pin_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [FLAG_W-1:0] reg_wdata_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  output logic              flag_tx_o,
  output logic              flag_al_o,
  output logic              irq_o
);
  logic              rst_ns;
  bus_evt_t          evt;
  logic              sda_s;
  logic              tx_sel_q;
  logic              tsel_rise;
  logic              mismatch, start_loss;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags;

  // reset: asserted asynchronously, released on the clock
  i2cst_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_ns)
  );

  i2cst_bus_evt #(.SYNC_STAGES(SYNC_STAGES)) u_bus_evt (
    .clk(clk), .rst_n(rst_ns), .scl_pin_i(scl_pin_i), .sda_pin_i(sda_pin_i),
    .evt_o(evt), .sda_s_o(sda_s)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) tx_sel_q <= 1'b0;
    else         tx_sel_q <= tx_sel_i;
  end

  always_comb begin
    tsel_rise  = tx_sel_i & ~tx_sel_q;
    mismatch   = mst_i & tx_sel_i & evt.scl_rise & (sda_drive_i ^ sda_s);
    start_loss = mst_i & evt.start & sda_drive_i;
    set_vec          = '0;
    clr_vec          = '0;
    set_vec[IDX_TX]  = xfer_load_i | tsel_rise;
    clr_vec[IDX_TX]  = txbuf_wr_i;
    set_vec[IDX_AL]  = mismatch | start_loss;
  end

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      i2cst_flag_cell u_cell (
        .clk(clk), .rst_n(rst_ns),
        .set_i(set_vec[i]), .hw_clr_i(clr_vec[i]),
        .rd_i(reg_rd_i), .wr_i(reg_wr_i), .wbit_i(reg_wdata_i[i]),
        .flag_o(flags[i])
      );
    end
  endgenerate

  assign flag_tx_o = flags[IDX_TX];
  assign flag_al_o = flags[IDX_AL];
  assign irq_o     = |(flags & irq_en_i);
endmodule

// File: rtl/i2cst_checker.sv
module i2cst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_load,
  input logic       txbuf_wr,
  input logic       tx_sel,
  input logic       reg_wr,
  input logic [1:0] wdata,
  input logic       flag_tx,
  input logic       flag_al,
  input logic       irq
);
  p_load_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |=> flag_tx);

  p_tsel_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sel) |=> flag_tx);

  p_bufwr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && !xfer_load && !tx_sel) |=> !flag_tx);

  p_tx_write_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tx && !txbuf_wr && !(reg_wr && !wdata[1])) |=> flag_tx);

  p_al_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_al && !(reg_wr && !wdata[0])) |=> flag_al);

  p_al_fall_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_al) |-> $past(reg_wr && !wdata[0]));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_tx || flag_al));
endmodule

bind i2c_status_flags i2cst_checker u_chk (
  .clk(clk), .rst_n(rst_ns), .xfer_load(xfer_load_i), .txbuf_wr(txbuf_wr_i),
  .tx_sel(tx_sel_i), .reg_wr(reg_wr_i), .wdata(reg_wdata_i),
  .flag_tx(flag_tx_o), .flag_al(flag_al_o), .irq(irq_o)
);

// File: tb/i2c_status_flags_tb.sv
`timescale 1ns/1ps
module i2c_status_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_load = 0, txbuf_wr = 0, mst = 0, tx_sel = 0, sda_drv = 1;
  logic       scl_pin = 1, sda_pin = 1, reg_rd = 0, reg_wr = 0;
  logic [1:0] wdata = 2'b11, irq_en = 2'b00;
  logic       flag_tx, flag_al, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  i2c_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_load_i(xfer_load), .txbuf_wr_i(txbuf_wr),
    .mst_i(mst), .tx_sel_i(tx_sel), .sda_drive_i(sda_drv),
    .scl_pin_i(scl_pin), .sda_pin_i(sda_pin), .reg_rd_i(reg_rd),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .irq_en_i(irq_en),
    .flag_tx_o(flag_tx), .flag_al_o(flag_al), .irq_o(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_read();
    reg_rd = 1; cyc(1); reg_rd = 0;
  endtask

  task automatic do_write(input logic [1:0] d);
    wdata = d; reg_wr = 1; cyc(1); reg_wr = 0; wdata = 2'b11;
  endtask

  task automatic pulse_load();
    xfer_load = 1; cyc(1); xfer_load = 0;
  endtask

  task automatic pulse_bufwr();
    txbuf_wr = 1; cyc(1); txbuf_wr = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(4);
    // R1 reset state
    chk(flag_tx, 1'b0, "R1 tdre");
    chk(flag_al, 1'b0, "R1 al");
    chk(irq, 1'b0, "R1 irq");

    // R2 transfer strobe
    pulse_load();
    chk(flag_tx, 1'b1, "R2 load sets");
    // R10 enables
    for (int e = 0; e < 4; e++) begin
      irq_en = e[1:0]; cyc(1);
      chk(irq, e[1], "R10 irq gating tdre");
    end
    irq_en = 2'b00;
    // R4 buffer write
    pulse_bufwr();
    chk(flag_tx, 1'b0, "R4 bufwr clears");
    // R3 transmit select rise
    tx_sel = 1; cyc(1);
    chk(flag_tx, 1'b1, "R3 tsel rise sets");
    tx_sel = 0; cyc(1);

    // R7 write 0 without read
    do_write(2'b01);
    chk(flag_tx, 1'b1, "R7 unarmed write0");
    do_read(); do_write(2'b01);
    chk(flag_tx, 1'b0, "R7 armed write0 clears");
    // R7 write 1 no effect, R8 disarm after write
    pulse_load(); do_read(); do_write(2'b11);
    chk(flag_tx, 1'b1, "R7 write1 no effect");
    do_write(2'b01);
    chk(flag_tx, 1'b1, "R8 disarmed after write");
    do_read(); do_write(2'b01);
    chk(flag_tx, 1'b0, "R7 clear after rearm");
    // R7 read of 0 does not arm
    do_read(); pulse_load(); do_write(2'b01);
    chk(flag_tx, 1'b1, "R7 read of 0 no arm");
    pulse_bufwr();
    chk(flag_tx, 1'b0, "R4 bufwr clears again");

    // R9 set vs clear
    pulse_load(); do_read();
    wdata = 2'b01; reg_wr = 1; xfer_load = 1; cyc(1);
    reg_wr = 0; xfer_load = 0; wdata = 2'b11;
    chk(flag_tx, 1'b1, "R9 load beats sw clear");
    txbuf_wr = 1; xfer_load = 1; cyc(1); txbuf_wr = 0; xfer_load = 0;
    chk(flag_tx, 1'b1, "R9 load beats bufwr");
    pulse_bufwr();

    // R5 mismatch sweep over mode bits and data
    for (int i = 0; i < 16; i++) begin
      logic m, t, d, p, exp;
      m = i[3]; t = i[2]; d = i[1]; p = i[0];
      exp = m & t & (d != p);
      scl_pin = 0; cyc(3);
      mst = m; tx_sel = t; sda_drv = d; sda_pin = p; cyc(4);
      scl_pin = 1; cyc(4);
      chk(flag_al, exp, $sformatf("R5 mismatch m%0b t%0b d%0b p%0b", m, t, d, p));
      do_read(); do_write(2'b10); cyc(1);
      chk(flag_al, 1'b0, "R7 al cleared by read+write0");
    end

    // R6 start condition sweep
    tx_sel = 0;
    for (int j = 0; j < 4; j++) begin
      logic m, d;
      m = j[1]; d = j[0];
      scl_pin = 0; cyc(3); sda_pin = 1; cyc(3);
      mst = m; sda_drv = d;
      scl_pin = 1; cyc(4);
      sda_pin = 0; cyc(4);
      chk(flag_al, m & d, $sformatf("R6 start m%0b d%0b", m, d));
      scl_pin = 0; cyc(3); sda_pin = 1; cyc(3);
      do_read(); do_write(2'b10); cyc(1);
    end

    // R11 latency, R7 bufwr leaves AL, R10 al enable
    mst = 1; sda_drv = 1; scl_pin = 1; cyc(4);
    sda_pin = 0;
    cyc(2); chk(flag_al, 1'b0, "R11 not after second edge");
    cyc(1); chk(flag_al, 1'b1, "R11 after third edge");
    pulse_bufwr();
    chk(flag_al, 1'b1, "R7 bufwr leaves al");
    irq_en = 2'b01; cyc(1);
    chk(irq, 1'b1, "R10 irq from al");
    irq_en = 2'b00; cyc(1);
    chk(irq, 1'b0, "R10 al masked");
    scl_pin = 0; cyc(3); sda_pin = 1; cyc(3);
    do_read(); do_write(2'b10); cyc(1);
    chk(flag_al, 1'b0, "R7 al clear");

    // R9 for AL: mismatch event meets armed clear
    tx_sel = 1; mst = 1; sda_drv = 1; sda_pin = 0; scl_pin = 0; cyc(4);
    scl_pin = 1; cyc(4);
    scl_pin = 0; cyc(4);
    do_read();
    scl_pin = 1; cyc(2);
    wdata = 2'b10; reg_wr = 1; cyc(1); reg_wr = 0; wdata = 2'b11;
    chk(flag_al, 1'b1, "R9 al set beats clear");
    do_read(); do_write(2'b10); cyc(1);
    chk(flag_al, 1'b0, "R7 al clear after collision");

    done = 1;
    summary();
    $finish;
  end
endmodule